// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Write-Cycle Engine

This block models, in synchronous logic, the control side of an 8192 x 8 byte-wide nonvolatile memory whose storage is an on-chip register array. The asynchronous chip-enable, output-enable and write-enable pins are all active low. They pass through two-flop synchronisers. From these pins the block decodes reads, standby, write inhibit, self-timed byte writes and a chip clear. While a write or clear is in progress, the block pulls its busy line low. It also answers data-polling reads, so a host can tell when the write has finished.

A write begins when the later of chip enable and write enable goes low, and the address is captured at that point. When the first of the two rises, the block captures the data and starts an internal timer. When the timer expires, the target byte is erased and reprogrammed in a single step. The high-voltage conditions are modelled as plain flag inputs. A flag on output enable selects a chip clear. A flag on address bit 9 maps the top 32 addresses onto a separate signature row. A supply-good input blocks every write while it is low.

Top module: `pbyte_nvmem`

## Requirements
- R1: With ceN=0, oeN=0 and weN=1, the block drives dOutEn=1 and dOut equal to the byte stored at the 13-bit address addr. Outputs follow the pins after two synchroniser stages and one output register.
- R2: With ceN=1, dOutEn is 0 whatever the level of oeN.
- R3: The address is captured when the later of ceN and weN falls. The data is captured when the earlier of the two rises. Changes to addr after the start, or to dIn before the rise, do not alter this.
- R4: No write and no busy period occur when oeN is low during the pulse, or when supplyOk is low.
- R5: After the data is captured, busyDrvLo is 1 for exactly WRITE_CYC clock cycles. It then returns to 0, and the new byte is readable from then on.
- R6: During a write, a read of the last-written address returns {~data[7], 7'b0}. A read of any other address returns 8'h00.
- R7: A write attempt made while busyDrvLo is 1 is ignored and stores nothing.
- R8: With oeHv=1, a falling of both ceN and weN starts a chip clear. Every main-array byte becomes 8'hFF and the signature row is unchanged. busyDrvLo stays 1 for max(CLEAR_CYC, 8192) cycles.
- R9: With a9Hv=1, addresses 0x1FE0 to 0x1FFF read and write a separate 32-byte signature row. The main-array byte at the same address is left unchanged.
- R10: A byte write replaces every bit of the old byte, so bits may change from 0 to 1 as well as from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable pin, active low, asynchronous |
| oeN | input | 1 | Output enable pin, active low, asynchronous |
| weN | input | 1 | Write enable pin, active low, asynchronous |
| oeHv | input | 1 | Output enable held at programming voltage (chip clear) |
| a9Hv | input | 1 | Address bit 9 held at programming voltage (signature row) |
| supplyOk | input | 1 | Supply above the trip level; 0 inhibits writes |
| addr | input | 13 | Byte address |
| dIn | input | 8 | Write data from the bus |
| dOut | output | 8 | Read data to the bus |
| dOutEn | output | 1 | Bus drive enable for dOut |
| busyDrvLo | output | 1 | 1 = busy line pulled low (write or clear running) |

## Verification
The bench moves the address and the data while a write pulse is open. A design that latched either one at the wrong edge would store the wrong byte or store it at the wrong location. The bench polls during busy and reads a different address during busy. A design that returned the true byte, or did not invert bit 7, fails these reads. The bench also issues writes while busy, with output enable low, and with the supply flagged low. A design that leaked any of these into the array changes a byte that is read back later. After a chip clear, the bench reads a signature byte and the main byte at the same address. A clear that also wiped the signature row, or a row select that ignored its flag, shows up as a wrong value.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_WRITE, ST_CLEAR} nvbState_t;

  typedef struct packed {
    logic latchAddr;
    logic latchData;
    logic commit;
    logic clearStart;
    logic clearStep;
    logic writing;
    logic clearing;
  } nvbCmd_t;
endpackage

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
  import nvb_pkg::*;
#(
  parameter int WRITE_CYC  = 375000,
  parameter int CLEAR_LEN  = 1250000,
  parameter int MAIN_DEPTH = 8192
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceN,
  input  logic    oeN,
  input  logic    weN,
  input  logic    oeHv,
  input  logic    supplyOk,
  output nvbCmd_t cmd,
  output logic    rdEn,
  output logic    busy
);
  localparam int LONGEST = (CLEAR_LEN > WRITE_CYC) ? CLEAR_LEN : WRITE_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam int NPIN    = 3;

  logic [NPIN-1:0] pinRaw, pinSync;
  assign pinRaw = {ceN, oeN, weN};

  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    logic metaQ, syncQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        metaQ <= 1'b1;
        syncQ <= 1'b1;
      end else begin
        metaQ <= pinRaw[i];
        syncQ <= metaQ;
      end
    end
    assign pinSync[i] = syncQ;
  end

  logic ceS, oeS, weS;
  assign ceS = pinSync[2];
  assign oeS = pinSync[1];
  assign weS = pinSync[0];

  logic bothLow, bothLowQ, startEdge;
  assign bothLow   = !ceS && !weS;
  assign startEdge = bothLow && !bothLowQ;
  assign rdEn      = !ceS && !oeS && weS;

  nvbState_t st, stNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic writeLast, clearLast;
  assign writeLast = (cnt == CNT_W'(WRITE_CYC - 1));
  assign clearLast = (cnt == CNT_W'(CLEAR_LEN - 1));

  always_comb begin
    stNext  = st;
    cntNext = cnt;
    cmd     = '0;
    unique case (st)
      ST_IDLE: begin
        if (startEdge && supplyOk) begin
          if (oeHv) begin
            stNext = ST_CLEAR;
            cntNext = '0;
            cmd.clearStart = 1'b1;
          end else if (oeS) begin
            stNext = ST_ARMED;
            cmd.latchAddr = 1'b1;
          end
        end
      end
      ST_ARMED: begin
        if (!supplyOk || !oeS) begin
          stNext = ST_IDLE;
        end else if (!bothLow) begin
          stNext = ST_WRITE;
          cntNext = '0;
          cmd.latchData = 1'b1;
        end
      end
      ST_WRITE: begin
        cmd.writing = 1'b1;
        if (writeLast) begin
          stNext = ST_IDLE;
          cmd.commit = 1'b1;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_CLEAR: begin
        cmd.clearing  = 1'b1;
        cmd.clearStep = (cnt < CNT_W'(MAIN_DEPTH));
        if (clearLast) stNext = ST_IDLE;
        else cntNext = cnt + 1'b1;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      bothLowQ <= 1'b0;
    end else begin
      st       <= stNext;
      cnt      <= cntNext;
      bothLowQ <= bothLow;
    end
  end

  assign busy = (st == ST_WRITE) || (st == ST_CLEAR);

  // R5: a running write keeps going until its last counted cycle
  a_r5_write_holds: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_WRITE && !writeLast) |=> (st == ST_WRITE));
  // R5: the busy line is released right after the commit
  a_r5_ready_after_commit: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |=> !busy);
  // R4: low supply never lets a write begin
  a_r4_no_write_low_supply: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_WRITE && !supplyOk) |=> (st != ST_WRITE));
  // R4: output enable low during the pulse aborts it
  a_r4_oe_low_aborts: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ARMED && !oeS) |=> (st == ST_IDLE));
  // R7: a fresh start edge during busy does not re-arm
  a_r7_busy_ignores_start: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startEdge) |=> (st != ST_ARMED));
  // R8: the clear counter stays inside its window
  a_r8_clear_bound: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_CLEAR) |-> (cnt < CNT_W'(CLEAR_LEN)));
endmodule

// File: rtl/nvb_datapath.sv
module nvb_datapath
  import nvb_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int SIG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvbCmd_t           cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  input  logic              a9Hv,
  input  logic              rdEn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn
);
  localparam int MAIN_DEPTH = 1 << ADDR_W;
  localparam int SIG_DEPTH  = 1 << SIG_W;

  logic [DATA_W-1:0] mainMem [MAIN_DEPTH];
  logic [DATA_W-1:0] sigMem  [SIG_DEPTH];

  logic [ADDR_W-1:0] latAddr, clrIdx;
  logic              latSig;
  logic [DATA_W-1:0] latData;

  logic sigSel, pollHit;
  assign sigSel  = a9Hv && (&addr[ADDR_W-1:SIG_W]);
  assign pollHit = (addr == latAddr) && (sigSel == latSig);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr <= '0;
      latSig  <= 1'b0;
      latData <= '0;
      clrIdx  <= '0;
    end else begin
      if (cmd.latchAddr) begin
        latAddr <= addr;
        latSig  <= sigSel;
      end
      if (cmd.latchData) latData <= dIn;
      if (cmd.clearStart) clrIdx <= '0;
      else if (cmd.clearStep) clrIdx <= clrIdx + 1'b1;
    end
  end

  // storage keeps its content across reset
  always_ff @(posedge clk) begin
    if (cmd.commit) begin
      if (latSig) sigMem[latAddr[SIG_W-1:0]] <= latData;
      else mainMem[latAddr] <= latData;
    end else if (cmd.clearStep) begin
      mainMem[clrIdx] <= '1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dOut   <= '0;
      dOutEn <= 1'b0;
    end else begin
      dOutEn <= rdEn;
      if (!rdEn || cmd.clearing) dOut <= '0;
      else if (cmd.writing) dOut <= pollHit ? {~latData[DATA_W-1], {(DATA_W-1){1'b0}}} : '0;
      else if (sigSel) dOut <= sigMem[addr[SIG_W-1:0]];
      else dOut <= mainMem[addr];
    end
  end

  // R2: no read request, no bus drive on the next cycle
  a_r2_no_drive_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !dOutEn);
  // R6: polling a running write returns inverted bit 7 and zeros below
  a_r6_poll_value: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.writing && rdEn && pollHit) |=>
      (dOut == {~$past(latData[DATA_W-1]), {(DATA_W-1){1'b0}}}));
  // R3: the captured address does not move while the write runs
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.writing && !cmd.commit) |=> $stable(latAddr));
endmodule

// File: rtl/pbyte_nvmem.sv
module pbyte_nvmem
  import nvb_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int SIG_W     = 5,
  parameter int WRITE_CYC = 375000,
  parameter int CLEAR_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              oeHv,
  input  logic              a9Hv,
  input  logic              supplyOk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn,
  output logic              busyDrvLo
);
  localparam int MAIN_DEPTH = 1 << ADDR_W;
  localparam int CLEAR_LEN  = (CLEAR_CYC > MAIN_DEPTH) ? CLEAR_CYC : MAIN_DEPTH;

  nvbCmd_t cmd;
  logic    rdEn;

  nvb_ctrl #(
    .WRITE_CYC (WRITE_CYC),
    .CLEAR_LEN (CLEAR_LEN),
    .MAIN_DEPTH(MAIN_DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .oeHv(oeHv), .supplyOk(supplyOk), .cmd(cmd), .rdEn(rdEn), .busy(busyDrvLo)
  );

  nvb_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_W(SIG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .addr(addr), .dIn(dIn), .a9Hv(a9Hv),
    .rdEn(rdEn), .dOut(dOut), .dOutEn(dOutEn)
  );
endmodule

// File: tb/tb_pbyte_nvmem.sv
`timescale 1ns/1ps
module tb_pbyte_nvmem;
  localparam int WC = 40;
  localparam int CC = 100;
  localparam int DEPTH = 8192;
  localparam int CLEN = (CC > DEPTH) ? CC : DEPTH;

  logic clk = 1'b0, rstN = 1'b0;
  logic ceN = 1, oeN = 1, weN = 1, oeHv = 0, a9Hv = 0, supplyOk = 1;
  logic [12:0] addr = '0;
  logic [7:0] dIn = '0, dOut;
  logic dOutEn, busyDrvLo;

  int errors = 0, checks = 0, cycles = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] sigModel [32];

  always #4 clk = ~clk;

  pbyte_nvmem #(.WRITE_CYC(WC), .CLEAR_CYC(CC)) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .oeHv(oeHv),
    .a9Hv(a9Hv), .supplyOk(supplyOk), .addr(addr), .dIn(dIn), .dOut(dOut),
    .dOutEn(dOutEn), .busyDrvLo(busyDrvLo)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pollVal(logic [7:0] d);
    return {~d[7], 7'b0};
  endfunction

  task automatic readAt(logic [12:0] a, logic sig, output logic [7:0] v, output logic en);
    addr = a; a9Hv = sig; ceN = 0; oeN = 0; weN = 1;
    tick(5);
    v = dOut; en = dOutEn;
    ceN = 1; oeN = 1; a9Hv = 0;
    tick(4);
  endtask

  // WE-controlled write: CE low first, WE pulse inside
  task automatic writeWe(logic [12:0] a, logic [7:0] d, logic sig);
    ceN = 0; tick(2);
    addr = a; dIn = d; a9Hv = sig; weN = 0;
    tick(6);
    weN = 1; tick(5);
    ceN = 1; a9Hv = 0;
  endtask

  task automatic readChk(string req, logic [12:0] a, logic sig, logic [7:0] exp);
    logic [7:0] v; logic en;
    readAt(a, sig, v, en);
    chk(req, {23'b0, en, v}, {23'b0, 1'b1, exp});
  endtask

  initial begin
    logic [7:0] v; logic en;
    logic [12:0] ra; logic [7:0] rd;
    void'($urandom(32'd7351));
    tick(3);
    chk("R5 reset busy", busyDrvLo, 0);
    chk("R2 reset drive", dOutEn, 0);
    rstN = 1; tick(3);

    // R9: signature byte before clear
    writeWe(13'h1FE3, 8'h5A, 1'b1); sigModel[3] = 8'h5A;
    tick(WC + 8);

    // R8: chip clear
    ceN = 0; weN = 0; oeHv = 1; tick(6);
    ceN = 1; weN = 1; oeHv = 0; tick(4);
    chk("R8 busy during clear", busyDrvLo, 1);
    tick(CLEN - 20);
    chk("R8 still busy near end", busyDrvLo, 1);
    tick(30);
    chk("R8 ready after clear", busyDrvLo, 0);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    readChk("R8 main cleared low", 13'h0000, 0, 8'hFF);
    readChk("R8 main cleared top", 13'h1FFF, 0, 8'hFF);
    readChk("R8 signature kept", 13'h1FE3, 1, 8'h5A);
    readChk("R9 main at sig address", 13'h1FE3, 0, 8'hFF);

    // R2: standby with OE low
    ceN = 1; oeN = 0; addr = 13'h0010; tick(5);
    chk("R2 standby no drive", dOutEn, 0);
    oeN = 1; tick(3);

    // R9: signature write leaves main alone
    writeWe(13'h1FE7, 8'hC3, 1'b1); sigModel[7] = 8'hC3;
    tick(WC + 8);
    readChk("R9 signature readback", 13'h1FE7, 1, 8'hC3);
    readChk("R9 main untouched", 13'h1FE7, 0, 8'hFF);

    // R3: CE-controlled, address moves after start, data moves before rise
    weN = 0; tick(2);
    addr = 13'h0123; dIn = 8'h11; ceN = 0; tick(6);
    addr = 13'h0456; dIn = 8'h9C; tick(4);
    ceN = 1; tick(5); weN = 1;
    model[13'h0123] = 8'h9C;
    tick(WC + 8);
    readChk("R3 start address holds late data", 13'h0123, 0, 8'h9C);
    readChk("R3 moved-to address untouched", 13'h0456, 0, 8'hFF);

    // R10: bits rise and fall
    writeWe(13'h0200, 8'h0F, 0); tick(WC + 8);
    writeWe(13'h0200, 8'hF0, 0); tick(WC + 8); model[13'h0200] = 8'hF0;
    readChk("R10 full replace", 13'h0200, 0, 8'hF0);

    // R4: OE low during pulse
    ceN = 0; oeN = 0; tick(2); addr = 13'h0300; dIn = 8'h12; weN = 0; tick(6);
    weN = 1; tick(3); ceN = 1; oeN = 1; tick(4);
    chk("R4 oe low no busy", busyDrvLo, 0);
    readChk("R4 oe low no store", 13'h0300, 0, 8'hFF);

    // R4: supply low
    supplyOk = 0;
    writeWe(13'h0301, 8'h34, 0); tick(4);
    chk("R4 supply low no busy", busyDrvLo, 0);
    supplyOk = 1;
    readChk("R4 supply low no store", 13'h0301, 0, 8'hFF);

    // R7 and R6: attempt and read during busy
    writeWe(13'h0400, 8'h2B, 0); model[13'h0400] = 8'h2B;
    writeWe(13'h0401, 8'h77, 0);
    readAt(13'h0402, 0, v, en);
    chk("R6 other address during busy", {en, v}, {1'b1, 8'h00});
    tick(WC + 8);
    readChk("R7 busy attempt ignored", 13'h0401, 0, 8'hFF);
    readChk("R7 first write stored", 13'h0400, 0, 8'h2B);

    // R1 R5 R6: random writes with polling and readback
    for (int k = 0; k < 25; k++) begin
      ra = 13'($urandom % 8160);
      rd = 8'($urandom);
      if (k == 0) rd = 8'h80;
      if (k == 1) rd = 8'h7F;
      writeWe(ra, rd, 0);
      chk("R5 busy after write", busyDrvLo, 1);
      readAt(ra, 0, v, en);
      chk("R6 poll value", {en, v}, {1'b1, pollVal(rd)});
      tick(WC - 18);
      chk("R5 busy before expiry", busyDrvLo, 1);
      tick(14);
      chk("R5 ready after expiry", busyDrvLo, 0);
      model[ra] = rd;
      readChk("R1 readback", ra, 0, model[ra]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule